// File: doc/BRIEF.md
# Character Window Margin Controller

This block decides, tick by tick, whether the raster position lies inside the character display window. The raster position comes in as a horizontal tick counter and a line counter. Four programmable fields set the window. A left-margin field counts in steps of 14 master ticks (4 pixels) plus a one-tick offset. A top-margin field counts in steps of two lines, less a fixed offset. A column count sets the width in 28-tick character cells, and a row count sets the height in 8-line character rows. The block drives a horizontal enable, a vertical enable, a pulse at the start of every character cell and a pulse at the start of every character row, which a downstream fetch engine uses.

Settings that would break the picture are clamped instead of passed through. A zero left margin is treated as one step. The window can never open inside the 9-line vertical interval. The window is cut off at the end of the line and at the end of the frame. The four fields are captured only at frame start, so a window never changes shape part-way through a frame. All four outputs are registered and follow the counters by one clock.

Top module: `dwin_margin_ctrl`

## Requirements
- R1: With `hcount` 0 at the first tick of a 910-tick line and the active region starting at tick 208, the horizontal window opens at tick 209 + 14*N, where N is the 7-bit `left_units` field.
- R2: A `left_units` value of 0 behaves exactly like a value of 1, so the window opens at tick 223.
- R3: The horizontal window stays open for 28*`num_cols` ticks and closes after tick 909 at the latest, the last tick of the line.
- R4: With `vcount` 0 at the first line of the frame, the vertical window opens at line 2*V - 10, where V is the 8-bit `top_units` field (V = 25 gives line 40).
- R5: The vertical window never opens before line 9. Any V below 10 opens it at line 9.
- R6: The vertical window stays open for 8*`num_rows` lines and closes after line 260 at the latest, the last line of the 261-line frame.
- R7: `col_start` pulses for one cycle at the first tick of every 28-tick character cell, counted from the window's opening tick, and only while both windows are open.
- R8: `row_start` pulses together with the first `col_start` of a line, and only on the first line of each 8-line character row.
- R9: The four fields are captured only on a cycle with `hcount` = 0 and `vcount` = 0. After reset, all outputs are 0 and no window opens until the first capture.
- R10: Every output reflects the counter values of the previous clock cycle (one register of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master tick clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | 10 | Tick within the line, 0 to 909 |
| vcount | input | 9 | Line within the frame, 0 to 260 |
| left_units | input | 7 | Left-margin field, 14-tick steps |
| top_units | input | 8 | Top-margin field, 2-line steps |
| num_cols | input | 7 | Character cells per line |
| num_rows | input | 6 | Character rows per frame |
| h_win | output | 1 | Horizontal window open |
| v_win | output | 1 | Vertical window open |
| row_start | output | 1 | First cell of a character row |
| col_start | output | 1 | First tick of a character cell |

## Verification
The window edges are tried with five field sets. One is the usual 22-column layout, and the others cover a zero left margin, top values small enough to be clamped, a width that overruns the line end, a height that overruns the frame end, and a window only one tick wide. Probing one tick either side of each edge separates an off-by-one in the affine margin arithmetic from a missing clamp. Full-line sweeps on the first line of a row, the line after it and the next row boundary separate cell pulse spacing from row-line selection. A field change without a frame-start position shows whether capture happens only at frame start.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  localparam int LINE_TICKS  = 910;
  localparam int ACT_START   = 208;
  localparam int FRAME_LINES = 261;
  localparam int VBL_LINES   = 9;
  localparam int COL_TICKS   = 28;
  localparam int LM_STEP     = 14;
  localparam int ROW_LINES   = 8;
  localparam int TM_OFFSET   = 10;
endpackage

// File: rtl/dwin_shape.sv
// Captures the margin fields at frame start and turns them into clamped
// window bounds held steady for the whole frame.
module dwin_shape #(
  parameter int LM_W        = 7,
  parameter int TM_W        = 8,
  parameter int COL_W       = 7,
  parameter int ROW_W       = 6,
  parameter int HS_W        = 14,
  parameter int VS_W        = 11,
  parameter int LINE_TICKS  = dwin_pkg::LINE_TICKS,
  parameter int ACT_START   = dwin_pkg::ACT_START,
  parameter int FRAME_LINES = dwin_pkg::FRAME_LINES,
  parameter int VBL_LINES   = dwin_pkg::VBL_LINES,
  parameter int COL_TICKS   = dwin_pkg::COL_TICKS,
  parameter int LM_STEP     = dwin_pkg::LM_STEP,
  parameter int ROW_LINES   = dwin_pkg::ROW_LINES,
  parameter int TM_OFFSET   = dwin_pkg::TM_OFFSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [LM_W-1:0]  left_units,
  input  logic [TM_W-1:0]  top_units,
  input  logic [COL_W-1:0] num_cols,
  input  logic [ROW_W-1:0] num_rows,
  output logic [HS_W-1:0]  hstart_q,
  output logic [HS_W-1:0]  hend_q,
  output logic [VS_W-1:0]  vstart_q,
  output logic [VS_W-1:0]  vend_q
);
  logic [LM_W-1:0] lm_eff;
  logic [HS_W-1:0] hs, he_raw, he;
  logic [VS_W-1:0] tm2, vs, ve_raw, ve;

  always_comb begin
    lm_eff = (left_units == '0) ? LM_W'(1) : left_units;
    hs     = HS_W'(ACT_START + 1) + HS_W'(LM_STEP) * HS_W'(lm_eff);
    he_raw = hs + HS_W'(COL_TICKS) * HS_W'(num_cols);
    he     = (he_raw > HS_W'(LINE_TICKS)) ? HS_W'(LINE_TICKS) : he_raw;
    tm2    = VS_W'(top_units) << 1;
    vs     = (tm2 < VS_W'(TM_OFFSET + VBL_LINES)) ? VS_W'(VBL_LINES)
                                                  : tm2 - VS_W'(TM_OFFSET);
    ve_raw = vs + VS_W'(ROW_LINES) * VS_W'(num_rows);
    ve     = (ve_raw > VS_W'(FRAME_LINES)) ? VS_W'(FRAME_LINES) : ve_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hstart_q <= '0;
      hend_q   <= '0;
      vstart_q <= VS_W'(VBL_LINES);
      vend_q   <= VS_W'(VBL_LINES);
    end else if (frame_start) begin
      hstart_q <= hs;
      hend_q   <= he;
      vstart_q <= vs;
      vend_q   <= ve;
    end
  end

  assert_shape_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(hstart_q) && $stable(hend_q) && $stable(vstart_q) && $stable(vend_q)));
  assert_top_clear_of_vbl_R5: assert property (@(posedge clk) disable iff (rst)
    vstart_q >= VS_W'(VBL_LINES));
  assert_line_end_cap_R3: assert property (@(posedge clk) disable iff (rst)
    hend_q <= HS_W'(LINE_TICKS));
  assert_frame_end_cap_R6: assert property (@(posedge clk) disable iff (rst)
    vend_q <= VS_W'(FRAME_LINES));
endmodule

// File: rtl/dwin_hdec.sv
// Horizontal window decode and character-cell phase tracking.
module dwin_hdec #(
  parameter int HC_W      = 10,
  parameter int HS_W      = 14,
  parameter int COL_TICKS = dwin_pkg::COL_TICKS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [HC_W-1:0] hc,
  input  logic [HS_W-1:0] hstart,
  input  logic [HS_W-1:0] hend,
  output logic            hwin_nx,
  output logic            first_nx,
  output logic            colb_nx
);
  localparam int PH_W = $clog2(COL_TICKS);

  logic [HS_W-1:0] hc_x;
  logic [PH_W-1:0] ph;
  logic            at_start;

  always_comb begin
    hc_x     = HS_W'(hc);
    at_start = (hc_x == hstart);
    hwin_nx  = (hc_x >= hstart) && (hc_x < hend);
    first_nx = hwin_nx && at_start;
    colb_nx  = hwin_nx && (at_start || ph == '0);
  end

  // ph holds the cell phase of the tick currently on hc
  always_ff @(posedge clk) begin
    if (rst)                               ph <= '0;
    else if (at_start)                     ph <= PH_W'(1 % COL_TICKS);
    else if (ph == PH_W'(COL_TICKS - 1))   ph <= '0;
    else                                   ph <= ph + PH_W'(1);
  end

  assert_phase_bound_R7: assert property (@(posedge clk) disable iff (rst)
    ph < PH_W'(COL_TICKS));
endmodule

// File: rtl/dwin_vdec.sv
// Vertical window decode and character-row boundary detection.
module dwin_vdec #(
  parameter int VC_W      = 9,
  parameter int VS_W      = 11,
  parameter int ROW_LINES = dwin_pkg::ROW_LINES
) (
  input  logic [VC_W-1:0] vc,
  input  logic [VS_W-1:0] vstart,
  input  logic [VS_W-1:0] vend,
  output logic            vwin_nx,
  output logic            rowb_nx
);
  logic [VS_W-1:0] vc_x;

  // ROW_LINES must be a power of two
  always_comb begin
    vc_x    = VS_W'(vc);
    vwin_nx = (vc_x >= vstart) && (vc_x < vend);
    rowb_nx = vwin_nx && (((vc_x - vstart) & VS_W'(ROW_LINES - 1)) == '0);
  end
endmodule

// File: rtl/dwin_margin_ctrl.sv
module dwin_margin_ctrl #(
  parameter int HC_W        = 10,
  parameter int VC_W        = 9,
  parameter int LM_W        = 7,
  parameter int TM_W        = 8,
  parameter int COL_W       = 7,
  parameter int ROW_W       = 6,
  parameter int LINE_TICKS  = dwin_pkg::LINE_TICKS,
  parameter int ACT_START   = dwin_pkg::ACT_START,
  parameter int FRAME_LINES = dwin_pkg::FRAME_LINES,
  parameter int VBL_LINES   = dwin_pkg::VBL_LINES,
  parameter int COL_TICKS   = dwin_pkg::COL_TICKS,
  parameter int LM_STEP     = dwin_pkg::LM_STEP,
  parameter int ROW_LINES   = dwin_pkg::ROW_LINES,
  parameter int TM_OFFSET   = dwin_pkg::TM_OFFSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HC_W-1:0]  hcount,
  input  logic [VC_W-1:0]  vcount,
  input  logic [LM_W-1:0]  left_units,
  input  logic [TM_W-1:0]  top_units,
  input  logic [COL_W-1:0] num_cols,
  input  logic [ROW_W-1:0] num_rows,
  output logic             h_win,
  output logic             v_win,
  output logic             row_start,
  output logic             col_start
);
  localparam int HS_W = $clog2(ACT_START + 1 + LM_STEP * (2**LM_W) + COL_TICKS * (2**COL_W)) + 1;
  localparam int VS_W = $clog2(2 * (2**TM_W) + ROW_LINES * (2**ROW_W)) + 1;

  logic            frame_start;
  logic [HS_W-1:0] hstart, hend;
  logic [VS_W-1:0] vstart, vend;
  logic            hwin_nx, first_nx, colb_nx, vwin_nx, rowb_nx;

  assign frame_start = (hcount == '0) && (vcount == '0);

  dwin_shape #(
    .LM_W(LM_W), .TM_W(TM_W), .COL_W(COL_W), .ROW_W(ROW_W),
    .HS_W(HS_W), .VS_W(VS_W), .LINE_TICKS(LINE_TICKS), .ACT_START(ACT_START),
    .FRAME_LINES(FRAME_LINES), .VBL_LINES(VBL_LINES), .COL_TICKS(COL_TICKS),
    .LM_STEP(LM_STEP), .ROW_LINES(ROW_LINES), .TM_OFFSET(TM_OFFSET)
  ) u_shape (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .left_units(left_units), .top_units(top_units),
    .num_cols(num_cols), .num_rows(num_rows),
    .hstart_q(hstart), .hend_q(hend), .vstart_q(vstart), .vend_q(vend)
  );

  dwin_hdec #(.HC_W(HC_W), .HS_W(HS_W), .COL_TICKS(COL_TICKS)) u_hdec (
    .clk(clk), .rst(rst), .hc(hcount), .hstart(hstart), .hend(hend),
    .hwin_nx(hwin_nx), .first_nx(first_nx), .colb_nx(colb_nx)
  );

  dwin_vdec #(.VC_W(VC_W), .VS_W(VS_W), .ROW_LINES(ROW_LINES)) u_vdec (
    .vc(vcount), .vstart(vstart), .vend(vend),
    .vwin_nx(vwin_nx), .rowb_nx(rowb_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_win     <= 1'b0;
      v_win     <= 1'b0;
      col_start <= 1'b0;
      row_start <= 1'b0;
    end else begin
      h_win     <= hwin_nx;
      v_win     <= vwin_nx;
      col_start <= colb_nx && vwin_nx;
      row_start <= first_nx && rowb_nx;
    end
  end

  assert_hwin_after_active_R1: assert property (@(posedge clk) disable iff (rst)
    h_win |-> ($past(hcount) > HC_W'(ACT_START)));
  assert_vwin_clear_of_vbl_R5: assert property (@(posedge clk) disable iff (rst)
    v_win |-> ($past(vcount) >= VC_W'(VBL_LINES)));
  assert_col_inside_window_R7: assert property (@(posedge clk) disable iff (rst)
    col_start |-> (h_win && v_win));
  assert_row_with_col_R8: assert property (@(posedge clk) disable iff (rst)
    row_start |-> col_start);
endmodule

// File: tb/dwin_margin_ctrl_tb.sv
`timescale 1ns/1ps
module dwin_margin_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] hcount;
  logic [8:0] vcount;
  logic [6:0] left_units;
  logic [7:0] top_units;
  logic [6:0] num_cols;
  logic [5:0] num_rows;
  logic       h_win, v_win, row_start, col_start;

  always #4 clk = ~clk;

  dwin_margin_ctrl u_dut (
    .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
    .left_units(left_units), .top_units(top_units),
    .num_cols(num_cols), .num_rows(num_rows),
    .h_win(h_win), .v_win(v_win), .row_start(row_start), .col_start(col_start)
  );

  // fields: left, top, cols, rows | expected hstart, hend, vstart, vend
  localparam int NVEC = 5;
  localparam int VEC [NVEC][8] = '{
    '{ 5,  25, 22, 23, 279, 895,  40, 224},
    '{ 0,   9, 22, 10, 223, 839,   9,  89},
    '{20,   3, 22, 40, 489, 910,   9, 261},
    '{ 1,  10,  1,  1, 223, 251,  10,  18},
    '{50, 100,  5, 10, 909, 910, 190, 261}
  };

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at the next falling edge with outputs
  // reflecting the driven counters
  task automatic probe(input int h, input int v);
    hcount = 10'(h);
    vcount = 9'(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic capture();
    probe(0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic sweep(input int v, input int hs, input int he,
                       output int ncol, output int nrow, output int bad);
    ncol = 0; nrow = 0; bad = 0;
    for (int h = 0; h < 910; h++) begin
      probe(h, v);
      if (col_start) ncol++;
      if (row_start) nrow++;
      if (col_start != (h >= hs && h < he && ((h - hs) % 28) == 0)) bad++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int ncol, nrow, bad;
    string hreq, vreq;
    rst = 1'b1; hcount = '0; vcount = '0;
    left_units = 7'd5; top_units = 8'd25; num_cols = 7'd22; num_rows = 6'd23;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", "reset h_win", int'(h_win), 0);
    chk("R9", "reset v_win", int'(v_win), 0);
    chk("R9", "reset col_start", int'(col_start), 0);
    chk("R9", "reset row_start", int'(row_start), 0);
    rst = 1'b0;
    probe(300, 100);
    chk("R9", "no window before capture h", int'(h_win), 0);
    chk("R9", "no window before capture v", int'(v_win), 0);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      left_units = 7'(VEC[i][0]); top_units = 8'(VEC[i][1]);
      num_cols   = 7'(VEC[i][2]); num_rows  = 6'(VEC[i][3]);
      hreq = (VEC[i][0] == 0) ? "R2" : "R1";
      vreq = (VEC[i][1] < 10) ? "R5" : "R4";
      capture();
      probe(VEC[i][4] - 1, VEC[i][6]);
      chk(hreq, $sformatf("vec%0d h before start", i), int'(h_win), 0);
      probe(VEC[i][4], VEC[i][6]);
      chk(hreq, $sformatf("vec%0d h at start", i), int'(h_win), 1);
      chk(vreq, $sformatf("vec%0d v at start", i), int'(v_win), 1);
      chk("R7", $sformatf("vec%0d first cell", i), int'(col_start), 1);
      chk("R8", $sformatf("vec%0d first row", i), int'(row_start), 1);
      probe(VEC[i][5] - 1, VEC[i][6]);
      chk("R3", $sformatf("vec%0d h last tick", i), int'(h_win), 1);
      if (VEC[i][5] < 910) begin
        probe(VEC[i][5], VEC[i][6]);
        chk("R3", $sformatf("vec%0d h after end", i), int'(h_win), 0);
      end
      probe(0, VEC[i][6] - 1);
      chk(vreq, $sformatf("vec%0d v line before", i), int'(v_win), 0);
      probe(0, VEC[i][7] - 1);
      chk("R6", $sformatf("vec%0d v last line", i), int'(v_win), 1);
      if (VEC[i][7] < 261) begin
        probe(0, VEC[i][7]);
        chk("R6", $sformatf("vec%0d v after end", i), int'(v_win), 0);
      end
    end

    // R7 R8 full-line sweeps with the usual layout
    left_units = 7'd5; top_units = 8'd25; num_cols = 7'd22; num_rows = 6'd23;
    capture();
    sweep(40, 279, 895, ncol, nrow, bad);
    chk("R7", "cell pulse misplacements", bad, 0);
    chk("R7", "cell pulses per line", ncol, 22);
    chk("R8", "row pulses on row line", nrow, 1);
    sweep(41, 279, 895, ncol, nrow, bad);
    chk("R8", "row pulses mid row", nrow, 0);
    chk("R7", "cell pulses mid row", ncol, 22);
    sweep(48, 279, 895, ncol, nrow, bad);
    chk("R8", "row pulses next row", nrow, 1);
    sweep(30, 279, 895, ncol, nrow, bad);
    chk("R7", "no cells above window", ncol, 0);

    // R10 one-cycle latency
    probe(278, 40);
    chk("R10", "h before edge tick", int'(h_win), 0);
    hcount = 10'd279;
    #1;
    chk("R10", "output held before clock", int'(h_win), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "output after one clock", int'(h_win), 1);

    // R9 fields ignored until frame start
    left_units = 7'd10; top_units = 8'd30;
    probe(279, 40);
    chk("R9", "old left margin kept", int'(h_win), 1);
    chk("R9", "old top margin kept", int'(v_win), 1);
    capture();
    probe(279, 40);
    chk("R9", "new left margin applied", int'(h_win), 0);
    chk("R9", "new top margin applied", int'(v_win), 0);
    probe(349, 50);
    chk("R9", "new window start h", int'(h_win), 1);
    chk("R9", "new window start v", int'(v_win), 1);

    done = 1'b1;
    finish_run();
  end
endmodule